// File: doc/BRIEF.md
# Touch Interrupt Request Controller

This block produces the active-low touch interrupt of a four-wire resistive panel controller. While sensing is armed, a touch on the panel asserts a pull-down enable. That enable drives an open-drain pad, and an external resistor pulls the pad high when the enable is off. The touch-sense input is a digitized level that can arrive at any time, so it passes through a synchronizer before it has any effect.

The serial front end reports four things to the block. It strobes when a start bit is recognised. It gives a count and a strobe for each falling serial-clock edge after that start bit. It strobes at the end of each conversion, and it supplies the two power-management bits loaded from the current control word.

A start bit disarms sensing at once. A pull-down that is already active stays active until a fixed falling edge after the start bit, so the pad does not glitch while the conversion begins. Sensing is armed again only at the end of a conversion, and only when the newly loaded power bits allow it. A separate output asks the panel driver to keep the lower Y-plate switch on for as long as sensing is armed.

Top module: `pen_irq_top`

## Requirements
- R1: After reset, sensing is armed (`irq_armed`=1), `irq_pull_en`=0 and `ydrv_hold`=1.
- R2: While armed with no start strobe, a rise of `touch_raw` sets `irq_pull_en` after exactly three rising clock edges: two synchronizer stages and one output register.
- R3: While armed, a fall of `touch_raw` clears `irq_pull_en` after the same three-edge latency.
- R4: A `start_det` pulse clears `irq_armed` at the next edge. From then on, touches cannot set `irq_pull_en`.
- R5: If `irq_pull_en` is 1 when start is detected, it stays 1 until a cycle with `fall_evt`=1 and `fall_cnt`=4. It clears at the edge that ends that cycle.
- R6: At an `eoc` pulse with no start in the same cycle, `irq_armed` becomes 1 when `pd_bits`=00 or 10 and 0 when `pd_bits`=01 or 11. Here `pd_bits[0]` is the low power bit, and a value of 0 in that bit arms sensing.
- R7: When `start_det` and `eoc` are both high in the same cycle, the start wins and sensing stays disarmed. As a result, back-to-back control words never re-arm sensing.
- R8: Once disarmed, sensing stays disarmed for any number of cycles until an `eoc` arrives. This covers an aborted conversion that never ends.
- R9: `ydrv_hold` equals `irq_armed` in every cycle.
- R10: Falling-edge strobes whose count is not 4 do not release a held pull-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| touch_raw | input | 1 | Asynchronous digitized touch-sense level, 1 = touched |
| start_det | input | 1 | One-cycle strobe: start bit recognised |
| fall_evt | input | 1 | One-cycle strobe: a falling serial-clock edge occurred |
| fall_cnt | input | 5 | Number of falling edges since start, valid with `fall_evt` |
| eoc | input | 1 | One-cycle strobe: conversion completed |
| pd_bits | input | 2 | Power bits of the current control word |
| irq_pull_en | output | 1 | 1 = drive the open-drain interrupt pad low |
| irq_armed | output | 1 | Sensing-armed status |
| ydrv_hold | output | 1 | Request to keep the lower Y-plate driver on |

## Verification
The arm state and `ydrv_hold` follow a start or end-of-conversion strobe at the first rising edge after it. A touch edge reaches `irq_pull_en` at the third edge. A held pull-down drops at the first edge after the qualifying falling-edge strobe. The bench drives every input just after a falling edge and updates its reference model on each rising edge from those settled inputs. It then compares all three outputs at the next falling edge, so each result is checked in exactly the cycle it is due. Targeted checks also sample the output one cycle early, to confirm that the latency is not shorter than specified.

// File: rtl/pen_irq_pkg.sv
package pen_irq_pkg;

  // Power-bit decode: low bit clear means sensing is allowed.
  function automatic logic pd_allows_arm(input logic [1:0] pd);
    return (pd[0] == 1'b0);
  endfunction

  // Held pull-down is released on the chosen falling edge after start.
  function automatic logic is_release_edge(input logic evt,
                                           input logic [4:0] cnt,
                                           input logic [4:0] target);
    return evt && (cnt == target);
  endfunction

endpackage

// File: rtl/pen_sync.sv
module pen_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pen_arm_ctrl.sv
module pen_arm_ctrl
  import pen_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_det,
  input  logic       eoc,
  input  logic [1:0] pd_bits,
  output logic       armed
);
  logic rearm_ok;
  assign rearm_ok = pd_allows_arm(pd_bits);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         armed <= 1'b1;
    else if (start_det) armed <= 1'b0;
    else if (eoc)       armed <= rearm_ok;

  // R4 / R7: start always disarms, even alongside eoc
  a_r4_start_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !armed);
  // R6: an eoc alone loads the arm state from the power bits
  a_r6_eoc_pd_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !start_det && pd_bits[0] == 1'b0) |=> armed);
  a_r6_eoc_pd_off: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !start_det && pd_bits[0] == 1'b1) |=> !armed);
  // R8: no path back to armed except through eoc
  a_r8_stay_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !eoc) |=> !armed);
endmodule

// File: rtl/pen_pull_ctrl.sv
module pen_pull_ctrl
  import pen_irq_pkg::*;
#(
  parameter int          CNT_W        = 5,
  parameter logic [4:0]  RELEASE_EDGE = 5'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             start_det,
  input  logic             touch_s,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] fall_cnt,
  output logic             pull_en
);
  logic follow_touch;
  logic release_hit;

  assign follow_touch = armed && !start_det;
  assign release_hit  = is_release_edge(fall_evt, 5'(fall_cnt), RELEASE_EDGE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            pull_en <= 1'b0;
    else if (follow_touch) pull_en <= touch_s;
    else if (release_hit)  pull_en <= 1'b0;

  // R4: once disarmed, a released output cannot be set by touch
  a_r4_no_touch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pull_en) |=> !pull_en);
  // R5: the qualifying falling edge releases a held pull-down
  a_r5_release_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && release_hit) |=> !pull_en);
  // R10: other falling edges keep it held
  a_r10_hold_other_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && pull_en && !release_hit) |=> pull_en);
  // R5: start itself does not drop an active pull-down
  a_r5_start_keeps_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && pull_en && !release_hit) |=> pull_en);
endmodule

// File: rtl/pen_irq_top.sv
module pen_irq_top #(
  parameter int         SYNC_STAGES  = 2,
  parameter int         CNT_W        = 5,
  parameter logic [4:0] RELEASE_EDGE = 5'd4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_raw,
  input  logic             start_det,
  input  logic             fall_evt,
  input  logic [CNT_W-1:0] fall_cnt,
  input  logic             eoc,
  input  logic [1:0]       pd_bits,
  output logic             irq_pull_en,
  output logic             irq_armed,
  output logic             ydrv_hold
);
  logic touch_s;
  logic armed_w;

  pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(touch_raw), .q_sync(touch_s));

  pen_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .start_det(start_det), .eoc(eoc),
    .pd_bits(pd_bits), .armed(armed_w));

  pen_pull_ctrl #(.CNT_W(CNT_W), .RELEASE_EDGE(RELEASE_EDGE)) u_pull (
    .clk(clk), .rst_n(rst_n), .armed(armed_w), .start_det(start_det),
    .touch_s(touch_s), .fall_evt(fall_evt), .fall_cnt(fall_cnt),
    .pull_en(irq_pull_en));

  assign irq_armed = armed_w;
  assign ydrv_hold = armed_w;

  // R9: driver hold request tracks the arm state
  a_r9_hold_tracks_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ydrv_hold == irq_armed);
endmodule

// File: tb/pen_irq_top_tb_top.sv
module pen_irq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       touch_raw = 1'b0;
  logic       start_det = 1'b0;
  logic       fall_evt = 1'b0;
  logic [4:0] fall_cnt = 5'd0;
  logic       eoc = 1'b0;
  logic [1:0] pd_bits = 2'b10;
  logic       irq_pull_en, irq_armed, ydrv_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  string phase = "R1";

  // reference model state
  bit m_armed = 1'b1;
  bit m_pull = 1'b0;
  bit sync_q[$] = '{1'b0, 1'b0};

  always #4 clk = ~clk;

  pen_irq_top dut_i (
    .clk(clk), .rst_n(rst_n), .touch_raw(touch_raw), .start_det(start_det),
    .fall_evt(fall_evt), .fall_cnt(fall_cnt), .eoc(eoc), .pd_bits(pd_bits),
    .irq_pull_en(irq_pull_en), .irq_armed(irq_armed), .ydrv_hold(ydrv_hold));

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = 1'b1; m_pull = 1'b0; sync_q = '{1'b0, 1'b0};
    end else begin
      bit np, na, rel;
      rel = fall_evt && (fall_cnt == 5'd4);
      np = (m_armed && !start_det) ? sync_q[0] : (m_pull && !rel);
      na = start_det ? 1'b0 : (eoc ? (pd_bits[0] == 1'b0) : m_armed);
      m_pull = np; m_armed = na;
      void'(sync_q.pop_front());
      sync_q.push_back(touch_raw);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(phase, irq_pull_en, m_pull, "model pull");
      chk(phase, irq_armed, m_armed, "model armed");
      chk("R9", ydrv_hold, m_armed, "model ydrv_hold");
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); #1 start_det = 1'b1;
    @(negedge clk); #1 start_det = 1'b0;
  endtask

  task automatic pulse_eoc(logic [1:0] pd);
    @(negedge clk); #1 eoc = 1'b1; pd_bits = pd;
    @(negedge clk); #1 eoc = 1'b0;
  endtask

  task automatic fall_strobe(logic [4:0] c);
    @(negedge clk); #1 fall_evt = 1'b1; fall_cnt = c;
    @(negedge clk); #1 fall_evt = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", irq_armed, 1'b1, "reset armed");
    chk("R1", irq_pull_en, 1'b0, "reset pull");
    chk("R1", ydrv_hold, 1'b1, "reset ydrv_hold");

    // R2 latency: touch set just after a negedge
    phase = "R2";
    #1 touch_raw = 1'b1;
    step(2); chk("R2", irq_pull_en, 1'b0, "pull after 2 edges");
    step(1); chk("R2", irq_pull_en, 1'b1, "pull after 3 edges");
    phase = "R3";
    #1 touch_raw = 1'b0;
    step(2); chk("R3", irq_pull_en, 1'b1, "still pulled after 2 edges");
    step(1); chk("R3", irq_pull_en, 1'b0, "released after 3 edges");

    // R4 / R5 / R10: start while pulled
    phase = "R5";
    #1 touch_raw = 1'b1;
    step(4);
    pulse_start();
    chk("R4", irq_armed, 1'b0, "disarmed after start");
    chk("R5", irq_pull_en, 1'b1, "pull held after start");
    #1 touch_raw = 1'b0;
    phase = "R10";
    fall_strobe(5'd1); fall_strobe(5'd2); fall_strobe(5'd3);
    step(3);
    chk("R10", irq_pull_en, 1'b1, "held across edges 1-3");
    phase = "R5";
    fall_strobe(5'd4);
    chk("R5", irq_pull_en, 1'b0, "released on edge 4");
    phase = "R4";
    #1 touch_raw = 1'b1;
    step(6);
    chk("R4", irq_pull_en, 1'b0, "touch ignored while disarmed");

    // R6: power-bit decode at eoc
    phase = "R6";
    pulse_eoc(2'b01);
    chk("R6", irq_armed, 1'b0, "pd 01 keeps disarmed");
    pulse_eoc(2'b11);
    chk("R6", irq_armed, 1'b0, "pd 11 keeps disarmed");
    pulse_eoc(2'b10);
    chk("R6", irq_armed, 1'b1, "pd 10 arms");
    step(2);
    chk("R6", irq_pull_en, 1'b1, "pull follows touch after rearm");
    #1 touch_raw = 1'b0;
    step(4);
    pulse_start();
    fall_strobe(5'd4);
    pulse_eoc(2'b00);
    chk("R6", irq_armed, 1'b1, "pd 00 arms");

    // R7: start and eoc together
    phase = "R7";
    @(negedge clk); #1 start_det = 1'b1; eoc = 1'b1; pd_bits = 2'b00;
    @(negedge clk); #1 start_det = 1'b0; eoc = 1'b0;
    chk("R7", irq_armed, 1'b0, "start wins over eoc");
    for (int k = 0; k < 4; k++) begin
      pulse_start();
      @(negedge clk); #1 start_det = 1'b1; eoc = 1'b1;
      @(negedge clk); #1 start_det = 1'b0; eoc = 1'b0;
    end
    chk("R7", irq_armed, 1'b0, "overlapped words never rearm");

    // R8: aborted conversion, no eoc for a long time
    phase = "R8";
    for (int k = 0; k < 10; k++) begin
      #1 touch_raw = ~touch_raw;
      step(5);
    end
    chk("R8", irq_armed, 1'b0, "stays disarmed without eoc");
    chk("R8", irq_pull_en, 1'b0, "no pull without eoc");
    chk("R9", ydrv_hold, 1'b0, "ydrv_hold off while disarmed");
    pulse_eoc(2'b10);
    chk("R8", irq_armed, 1'b1, "eoc finally rearms");
    chk("R9", ydrv_hold, 1'b1, "ydrv_hold back on");
    step(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule